// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm

This block keeps elapsed time as a binary count. A slow clock-enable pulse, nominally 32.768 kHz, runs through a two-stage prescaler. The first stage divides by 4096 and the second by 8, so one count tick comes out per second. Each tick advances a 32-bit up counter. When the alarm counter is enabled, the same tick also steps a 24-bit down counter. When that down counter expires, it sets a sticky alarm flag and reloads the interval that was last written to it. A shared active-low, open-drain style output shows one of two things, selected by a mode bit: the alarm interrupt or a square wave from the first prescaler stage.

A bus front end, which is not part of this block, decodes register addresses. It presents the block with write strobes and data for four targets: the time counter, the alarm interval, the control byte and the alarm-flag clear. The block returns the current counter values, the control byte, the flag and the pin level.

Control byte fields:
- bit 7: oscillator stop. It is active high, so 1 stops the oscillator.
- bit 3: alarm counter enable.
- bit 2: pin mode. 1 selects the interrupt and 0 selects the square wave.
- bit 0: alarm interrupt enable.

Top module: `etc_timekeeper`

## Requirements
- R1: After reset, the time count, the alarm count, the alarm flag and the control byte are all zero. The pin output is low, because it shows the square wave and the prescaler is at phase 0.
- R2: With control bit 7 at 0, the time count increases by one on every DIV1*DIV2-th oscillator pulse. It wraps from all ones to zero. The count changes in the clock cycle that registers that pulse.
- R3: With control bit 7 at 1, oscillator pulses are ignored. The prescaler phase, the time count and the alarm count all hold.
- R4: A time-count write loads all 32 bits in one cycle and clears both prescaler stages. The next tick therefore comes a full DIV1*DIV2 pulses later. When a write and a tick fall in the same cycle, the write wins.
- R5: An alarm write loads both the alarm count and the reload interval. With control bit 3 at 1, each tick decrements the alarm count. With bit 3 at 0, the alarm count holds. An alarm write in the same cycle as a tick takes precedence.
- R6: A tick that finds the alarm counter enabled and the alarm count at 1 or 0 expires the alarm. The flag is set and the count reloads from the interval, so the alarm repeats with the same period.
- R7: The alarm flag is sticky. A flag-clear write with data 0 clears it, and a flag-clear write with data 1 leaves it unchanged. An expiry in the same cycle as a clear keeps the flag set.
- R8: With control bit 2 at 1, the pin is low exactly when the flag and control bit 0 are both 1. Otherwise it is high.
- R9: With control bit 2 at 0, the pin follows the square wave. It is high while the first-stage prescaler phase is at least DIV1/2.
- R10: A control write stores the whole byte, and the byte reads back on the control output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_pulse_i | input | 1 | One-cycle pulse per oscillator period |
| cnt_wr_i | input | 1 | Time-count write strobe |
| cnt_wdata_i | input | COUNT_W | Time-count write data |
| alm_wr_i | input | 1 | Alarm interval write strobe |
| alm_wdata_i | input | ALARM_W | Alarm interval write data |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 8 | Control write data |
| flag_wr_i | input | 1 | Alarm flag write strobe |
| flag_wdata_i | input | 1 | Flag write value; 0 clears, 1 has no effect |
| count_o | output | COUNT_W | Elapsed time count |
| alm_count_o | output | ALARM_W | Alarm down count |
| alm_flag_o | output | 1 | Sticky alarm flag |
| ctrl_o | output | 8 | Control byte |
| pin_n_o | output | 1 | Shared pin level; 0 means pulled low |

## Verification
The bench builds the block with DIV1 = 4 and DIV2 = 2, so a tick arrives every 8 oscillator pulses. At these values, thousands of ticks, many alarm expiries and square-wave edges fit into a short run. The counter widths stay at 32 and 24 bits, so the wrap at all ones is exercised by loading the counter near its top. Small alarm intervals, including 0 and 1, make repeat expiries and their collisions with flag-clear writes frequent under random stimulus.

// File: rtl/etc_pkg.sv
package etc_pkg;
  localparam int CTRL_OSC_OFF   = 7;
  localparam int CTRL_ALM_CNT   = 3;
  localparam int CTRL_PIN_IRQ   = 2;
  localparam int CTRL_ALM_IRQ   = 0;
endpackage

// File: rtl/etc_prescaler.sv
module etc_prescaler #(
  parameter int DIV1 = 4096,
  parameter int DIV2 = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o,
  output logic sqw_o
);
  localparam int W1 = (DIV1 > 1) ? $clog2(DIV1) : 1;
  localparam int W2 = (DIV2 > 1) ? $clog2(DIV2) : 1;

  logic [W1-1:0] ph1_q;
  logic [W2-1:0] ph2_q;
  logic          wrap1, wrap2;

  assign wrap1  = (ph1_q == W1'(DIV1 - 1));
  assign wrap2  = (ph2_q == W2'(DIV2 - 1));
  assign tick_o = en_i && wrap1 && wrap2 && !clr_i;
  assign sqw_o  = (ph1_q >= W1'(DIV1 / 2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph1_q <= '0;
      ph2_q <= '0;
    end else if (clr_i) begin
      ph1_q <= '0;
      ph2_q <= '0;
    end else if (en_i) begin
      if (wrap1) begin
        ph1_q <= '0;
        ph2_q <= wrap2 ? '0 : ph2_q + W2'(1);
      end else begin
        ph1_q <= ph1_q + W1'(1);
      end
    end
  end
endmodule

// File: rtl/etc_up_counter.sv
module etc_up_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= data_i;
    else if (inc_i)  q_o <= q_o + W'(1);
  end
endmodule

// File: rtl/etc_alarm.sv
module etc_alarm #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         step_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);
  logic [W-1:0] reload_q;
  logic         expire;

  assign expire = step_i && !load_i && (cnt_o <= W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      cnt_o    <= data_i;
      reload_q <= data_i;
    end else if (step_i) begin
      cnt_o <= expire ? reload_q : cnt_o - W'(1);
    end
  end

  // set has priority so an expiry is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (expire) flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/etc_timekeeper.sv
module etc_timekeeper #(
  parameter int COUNT_W = 32,
  parameter int ALARM_W = 24,
  parameter int DIV1    = 4096,
  parameter int DIV2    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               osc_pulse_i,
  input  logic               cnt_wr_i,
  input  logic [COUNT_W-1:0] cnt_wdata_i,
  input  logic               alm_wr_i,
  input  logic [ALARM_W-1:0] alm_wdata_i,
  input  logic               ctrl_wr_i,
  input  logic [7:0]         ctrl_wdata_i,
  input  logic               flag_wr_i,
  input  logic               flag_wdata_i,
  output logic [COUNT_W-1:0] count_o,
  output logic [ALARM_W-1:0] alm_count_o,
  output logic               alm_flag_o,
  output logic [7:0]         ctrl_o,
  output logic               pin_n_o
);
  import etc_pkg::*;

  logic tick, sqw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_o <= '0;
    else if (ctrl_wr_i) ctrl_o <= ctrl_wdata_i;
  end

  etc_prescaler #(.DIV1(DIV1), .DIV2(DIV2)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (osc_pulse_i && !ctrl_o[CTRL_OSC_OFF]),
    .clr_i  (cnt_wr_i),
    .tick_o (tick),
    .sqw_o  (sqw)
  );

  etc_up_counter #(.W(COUNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_wr_i),
    .data_i (cnt_wdata_i),
    .inc_i  (tick),
    .q_o    (count_o)
  );

  etc_alarm #(.W(ALARM_W)) u_alm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (alm_wr_i),
    .data_i (alm_wdata_i),
    .step_i (tick && ctrl_o[CTRL_ALM_CNT]),
    .clr_i  (flag_wr_i && !flag_wdata_i),
    .cnt_o  (alm_count_o),
    .flag_o (alm_flag_o)
  );

  assign pin_n_o = ctrl_o[CTRL_PIN_IRQ] ? !(alm_flag_o && ctrl_o[CTRL_ALM_IRQ]) : sqw;
endmodule

// File: rtl/etc_checker.sv
module etc_checker #(
  parameter int COUNT_W = 32,
  parameter int ALARM_W = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               osc_pulse_i,
  input logic               cnt_wr_i,
  input logic               alm_wr_i,
  input logic               ctrl_wr_i,
  input logic               flag_wr_i,
  input logic               flag_wdata_i,
  input logic [COUNT_W-1:0] count_o,
  input logic [ALARM_W-1:0] alm_count_o,
  input logic               alm_flag_o,
  input logic [7:0]         ctrl_o,
  input logic               pin_n_o
);
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + COUNT_W'(1)));

  p_osc_off_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[7] && !cnt_wr_i && !alm_wr_i) |=> ($stable(count_o) && $stable(alm_count_o)));

  p_alarm_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[3] && !alm_wr_i) |=> $stable(alm_count_o));

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_flag_o && !(flag_wr_i && !flag_wdata_i)) |=> alm_flag_o);

  p_flag_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_flag_o) |-> ($past(ctrl_o[3]) && !$past(ctrl_o[7]) && $past(osc_pulse_i)));

  p_pin_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[2] && alm_flag_o && ctrl_o[0]) |-> !pin_n_o);

  p_ctrl_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr_i |=> $stable(ctrl_o));
endmodule

bind etc_timekeeper etc_checker #(.COUNT_W(COUNT_W), .ALARM_W(ALARM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .osc_pulse_i  (osc_pulse_i),
  .cnt_wr_i     (cnt_wr_i),
  .alm_wr_i     (alm_wr_i),
  .ctrl_wr_i    (ctrl_wr_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .count_o      (count_o),
  .alm_count_o  (alm_count_o),
  .alm_flag_o   (alm_flag_o),
  .ctrl_o       (ctrl_o),
  .pin_n_o      (pin_n_o)
);

// File: tb/sim_etc_timekeeper.sv
`timescale 1ns/1ps
module sim_etc_timekeeper;
  localparam int CW = 32;
  localparam int AW = 24;
  localparam int D1 = 4;
  localparam int D2 = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          osc = 1'b0;
  logic          cwr = 1'b0;
  logic [CW-1:0] cdat = '0;
  logic          awr = 1'b0;
  logic [AW-1:0] adat = '0;
  logic          kwr = 1'b0;
  logic [7:0]    kdat = '0;
  logic          fwr = 1'b0;
  logic          fdat = 1'b0;
  logic [CW-1:0] count;
  logic [AW-1:0] acount;
  logic          flag;
  logic [7:0]    ctrl;
  logic          pin_n;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  int            p1 = 0, p2 = 0;
  logic [CW-1:0] m_cnt = '0;
  logic [AW-1:0] m_alm = '0, m_rel = '0;
  logic          m_flag = 1'b0;
  logic [7:0]    m_ctrl = '0;

  always #4 clk = ~clk;

  etc_timekeeper #(.COUNT_W(CW), .ALARM_W(AW), .DIV1(D1), .DIV2(D2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_pulse_i(osc),
    .cnt_wr_i(cwr), .cnt_wdata_i(cdat), .alm_wr_i(awr), .alm_wdata_i(adat),
    .ctrl_wr_i(kwr), .ctrl_wdata_i(kdat), .flag_wr_i(fwr), .flag_wdata_i(fdat),
    .count_o(count), .alm_count_o(acount), .alm_flag_o(flag), .ctrl_o(ctrl),
    .pin_n_o(pin_n));

  function automatic logic exp_pin();
    if (m_ctrl[2]) return !(m_flag && m_ctrl[0]);
    return (p1 >= D1 / 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2/R4 count"}, count, m_cnt);
    chk({tag, " R5/R6 alarm count"}, 32'(acount), 32'(m_alm));
    chk({tag, " R6/R7 flag"}, 32'(flag), 32'(m_flag));
    chk({tag, " R10 ctrl"}, 32'(ctrl), 32'(m_ctrl));
    chk({tag, " R8/R9 pin"}, 32'(pin_n), 32'(exp_pin()));
  endtask

  // one clock cycle of stimulus, then model update
  task automatic step(input logic o, input logic cw, input logic [CW-1:0] cd,
                      input logic aw, input logic [AW-1:0] ad,
                      input logic kw, input logic [7:0] kd,
                      input logic fw, input logic fd);
    logic tick, expire;
    osc = o; cwr = cw; cdat = cd; awr = aw; adat = ad;
    kwr = kw; kdat = kd; fwr = fw; fdat = fd;
    @(posedge clk);
    #1;
    tick = o && !m_ctrl[7] && p1 == D1 - 1 && p2 == D2 - 1 && !cw;
    expire = tick && m_ctrl[3] && !aw && m_alm <= 1;
    if (cw) begin
      p1 = 0; p2 = 0;
    end else if (o && !m_ctrl[7]) begin
      if (p1 == D1 - 1) begin
        p1 = 0; p2 = (p2 == D2 - 1) ? 0 : p2 + 1;
      end else p1 = p1 + 1;
    end
    if (cw) m_cnt = cd;
    else if (tick) m_cnt = m_cnt + 1;
    if (aw) begin
      m_alm = ad; m_rel = ad;
    end else if (tick && m_ctrl[3]) m_alm = expire ? m_rel : m_alm - 1;
    if (expire) m_flag = 1'b1;
    else if (fw && !fd) m_flag = 1'b0;
    if (kw) m_ctrl = kd;
    osc = 0; cwr = 0; awr = 0; kwr = 0; fwr = 0;
  endtask

  task automatic idle(input logic o);
    step(o, 0, '0, 0, '0, 0, '0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 alarm", 32'(acount), 0);
    chk("R1 flag", 32'(flag), 0);
    chk("R1 ctrl", 32'(ctrl), 0);
    chk("R1 pin", 32'(pin_n), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: tick on 8th pulse
    for (int i = 0; i < 7; i++) idle(1);
    chk("R2 no tick yet", count, 0);
    idle(1);
    chk("R2 first tick", count, 1);
    check_all("R2");

    // R9 square wave after two pulses
    idle(1); idle(1);
    chk("R9 sqw high", 32'(pin_n), 1);
    check_all("R9");

    // R4 write clears prescaler, wins over tick
    step(1, 1, 32'hFFFF_FFFF, 0, '0, 0, '0, 0, 0);
    chk("R4 load", count, 32'hFFFF_FFFF);
    for (int i = 0; i < 7; i++) idle(1);
    chk("R4 full period", count, 32'hFFFF_FFFF);
    idle(1);
    chk("R2 wrap", count, 0);

    // R3 oscillator stopped
    step(0, 0, '0, 0, '0, 1, 8'h88, 0, 0);
    for (int i = 0; i < 20; i++) idle(1);
    chk("R3 stopped count", count, 0);
    check_all("R3");

    // R5/R6/R8 alarm with interval 2, interrupt mode
    step(0, 0, '0, 1, 24'd2, 1, 8'h0D, 0, 0);
    for (int i = 0; i < 8; i++) idle(1);
    chk("R5 decrement", 32'(acount), 1);
    for (int i = 0; i < 8; i++) idle(1);
    chk("R6 flag set", 32'(flag), 1);
    chk("R6 reload", 32'(acount), 2);
    chk("R8 pin low", 32'(pin_n), 0);
    // R7 write 1 no effect, write 0 clears
    step(0, 0, '0, 0, '0, 0, '0, 1, 1);
    chk("R7 write one keeps", 32'(flag), 1);
    step(0, 0, '0, 0, '0, 0, '0, 1, 0);
    chk("R7 clear", 32'(flag), 0);
    chk("R8 pin released", 32'(pin_n), 1);
    check_all("R7");

    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r;
      logic [7:0] kd;
      r = $urandom % 100;
      kd = 8'($urandom);
      if ($urandom % 4 != 0) kd[7] = 1'b0;
      step(($urandom % 3) != 0,
           r < 2, ($urandom % 2) ? 32'hFFFF_FFFE : 32'($urandom),
           r >= 2 && r < 6, 24'($urandom % 4),
           r >= 6 && r < 9, kd,
           r >= 9 && r < 20, 1'($urandom));
      check_all("rand");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule